// File: doc/BRIEF.md
# Overflow-Interrupt Up-Counting Timer

This block is a general-purpose timer whose counter climbs by one on every clock while it runs. It reports an event when the counter steps past its all-ones value. Software controls it through a small register bus where every access completes in a single cycle. To get an interval of N+1 cycles, software programs the reload value as the all-ones value minus N. It does not program a down-count.

Two modes select what happens at the wrap. In periodic mode the counter restarts from the reload register and keeps running. In one-shot mode the counter wraps to zero and the run bit drops by itself. Each wrap sets a sticky pending flag, and software clears the flag by writing a one to it. The interrupt line is the pending flag gated by an enable bit. A combined reload-and-start register writes the reload register and the counter together and sets the run bit, all in one access.

Top module: `gp_ovf_timer`

## Requirements
- R1: After reset the counter, reload value, control bits, enable bit and pending flag all read as zero, and `irq` is low.
- R2: While the run bit (control offset 0x00, bit 0) is set, the counter (offset 0x08) rises by exactly one each clock. While it is clear, the counter holds its value.
- R3: When the counter is at all-ones and running, the next clock sets the pending flag (offset 0x10, bit 0).
- R4: With auto-reload (control bit 1) set, that same clock loads the counter from the reload register (offset 0x04), and the run bit stays set.
- R5: With auto-reload clear, that same clock wraps the counter to zero and clears the run bit.
- R6: Writing 1 to bit 0 at offset 0x10 clears the pending flag. Writing 0 there leaves it alone. A wrap in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly when the pending flag and the enable bit (offset 0x0C, bit 0) are both set.
- R8: A write to offset 0x14 puts the write data into both the reload register and the counter and sets the run bit. The auto-reload bit keeps its value.
- R9: Writing the run bit to zero stops the counter without changing the reload register.
- R10: A bus write to the counter takes priority over counting in that cycle. Reads of the counter return its current value while it runs.
- R11: Accesses to unmapped addresses read as zero and change no state. Offset 0x14 also reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_ready | output | 1 | Access accepted (always in the same cycle) |
| bus_rdata | output | CNT_W | Read data, valid during a read cycle |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a clear of the pending flag that lands on the same clock as a wrap. The only way to get there is to load the counter a known small distance below all-ones and then time the clear write to the exact edge where the wrap happens. The bench uses the reload-and-start register with a value three below all-ones, waits a fixed number of idle cycles, and issues the clear on the wrap edge. It then reads back the flag to confirm that it stayed set. The cycle-accurate reference model confirms that each access lands where intended.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_LOAD = 4;
  localparam int unsigned OFS_CNT  = 8;
  localparam int unsigned OFS_IE   = 12;
  localparam int unsigned OFS_STS  = 16;
  localparam int unsigned OFS_LDST = 20;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_AR_BIT  = 1;
  localparam int unsigned FLAG_OVF_BIT = 0;

  typedef struct packed {
    logic ctrl;
    logic load;
    logic cnt;
    logic ie;
    logic sts;
    logic ldst;
  } wr_strobe_t;
endpackage

// File: rtl/tmr_regif.sv
`timescale 1ns/1ps
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_strobe_t        strb,
  output logic [DATA_W-1:0] rdata,
  input  logic              run,
  input  logic              ar,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] load,
  input  logic              ie,
  input  logic              sts
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_LDST = ADDR_W'(OFS_LDST);

  logic do_wr, do_rd;
  assign do_wr = bus_valid &  bus_write;
  assign do_rd = bus_valid & ~bus_write;

  always_comb begin
    strb.ctrl = do_wr & (bus_addr == A_CTRL);
    strb.load = do_wr & (bus_addr == A_LOAD);
    strb.cnt  = do_wr & (bus_addr == A_CNT);
    strb.ie   = do_wr & (bus_addr == A_IE);
    strb.sts  = do_wr & (bus_addr == A_STS);
    strb.ldst = do_wr & (bus_addr == A_LDST);
  end

  always_comb begin
    rdata = '0;
    if (do_rd) begin
      if (bus_addr == A_CTRL) begin
        rdata[CTRL_RUN_BIT] = run;
        rdata[CTRL_AR_BIT]  = ar;
      end else if (bus_addr == A_LOAD) begin
        rdata = load;
      end else if (bus_addr == A_CNT) begin
        rdata = cnt;
      end else if (bus_addr == A_IE) begin
        rdata[FLAG_OVF_BIT] = ie;
      end else if (bus_addr == A_STS) begin
        rdata[FLAG_OVF_BIT] = sts;
      end
    end
  end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       strb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] load_q,
  output logic             run_q,
  output logic             ar_q,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d, load_d;
  logic             run_d, ar_d, en;

  assign ovf = run_q & (cnt_q == CNT_MAX);
  assign en  = run_q | strb.ctrl | strb.load | strb.cnt | strb.ldst;

  always_comb begin
    cnt_d  = cnt_q;
    load_d = load_q;
    run_d  = run_q;
    ar_d   = ar_q;
    if (run_q) begin
      if (ovf) cnt_d = ar_q ? load_q : '0;
      else     cnt_d = cnt_q + CNT_W'(1);
    end
    if (ovf && !ar_q) run_d = 1'b0;
    if (strb.ctrl) begin
      run_d = wdata[CTRL_RUN_BIT];
      ar_d  = wdata[CTRL_AR_BIT];
    end
    if (strb.load) load_d = wdata;
    if (strb.cnt)  cnt_d  = wdata;
    if (strb.ldst) begin
      load_d = wdata;
      cnt_d  = wdata;
      run_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      run_q  <= 1'b0;
      ar_q   <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      run_q  <= run_d;
      ar_q   <= ar_d;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq
  import tmr_pkg::*;
#(
  parameter bit IRQ_REG = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  wr_strobe_t strb,
  input  logic       wbit,
  input  logic       ovf,
  output logic       ie_q,
  output logic       sts_q,
  output logic       irq
);
  logic ie_d, sts_d, sts_en;

  assign sts_en = ovf | strb.sts;

  always_comb begin
    ie_d  = strb.ie ? wbit : ie_q;
    sts_d = ovf | (sts_q & ~(strb.sts & wbit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (strb.ie) ie_q  <= ie_d;
      if (sts_en)  sts_q <= sts_d;
    end
  end

  generate
    if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ie_d & sts_d;
      end
      assign irq = irq_q;
    end else begin : g_irq_comb
      assign irq = ie_q & sts_q;
    end
  endgenerate
endmodule

// File: rtl/gp_ovf_timer.sv
`timescale 1ns/1ps
module gp_ovf_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter bit          IRQ_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic              bus_ready,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  wr_strobe_t       strb;
  logic [CNT_W-1:0] cnt_q, load_q;
  logic             run_q, ar_q, ovf, ie_q, sts_q;

  assign bus_ready = bus_valid;

  tmr_regif #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_regif (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .strb      (strb),
    .rdata     (bus_rdata),
    .run       (run_q),
    .ar        (ar_q),
    .cnt       (cnt_q),
    .load      (load_q),
    .ie        (ie_q),
    .sts       (sts_q)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wdata  (bus_wdata),
    .cnt_q  (cnt_q),
    .load_q (load_q),
    .run_q  (run_q),
    .ar_q   (ar_q),
    .ovf    (ovf)
  );

  tmr_irq #(.IRQ_REG(IRQ_REG)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .wbit  (bus_wdata[FLAG_OVF_BIT]),
    .ovf   (ovf),
    .ie_q  (ie_q),
    .sts_q (sts_q),
    .irq   (irq)
  );
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             run_q,
  input logic             ar_q,
  input logic             ie_q,
  input logic             sts_q,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic wr;
  assign wr = bus_valid & bus_write;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != CNT_MAX && !wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX) |=> sts_q); // R3
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX && ar_q && !wr) |=> (run_q && cnt_q == $past(load_q))); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX && !ar_q && !wr) |=> (!run_q && cnt_q == '0)); // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr) |=> ($stable(cnt_q) && $stable(load_q))); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q); // R7
endmodule

bind gp_ovf_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .cnt_q     (cnt_q),
  .load_q    (load_q),
  .run_q     (run_q),
  .ar_q      (ar_q),
  .ie_q      (ie_q),
  .sts_q     (sts_q),
  .irq       (irq)
);

// File: tb/sim_gp_ovf_timer.sv
`timescale 1ns/1ps
module sim_gp_ovf_timer;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam logic [W-1:0] MAXV = '1;

  logic          clk, rst_n;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [W-1:0]  bus_wdata;
  logic          bus_ready;
  logic [W-1:0]  bus_rdata;
  logic          irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  gp_ovf_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [W-1:0] m_cnt, m_load;
  logic         m_run, m_ar, m_ie, m_sts;

  always @(posedge clk or negedge rst_n) begin
    logic [W-1:0] c, l;
    logic r, a, e, s, wrap, clr;
    if (!rst_n) begin
      m_cnt <= 0; m_load <= 0; m_run <= 0; m_ar <= 0; m_ie <= 0; m_sts <= 0;
    end else begin
      c = m_cnt; l = m_load; r = m_run; a = m_ar; e = m_ie; s = m_sts;
      wrap = m_run && (m_cnt == MAXV);
      clr = 0;
      if (m_run) c = wrap ? (m_ar ? m_load : 0) : m_cnt + 1;
      if (wrap && !m_ar) r = 0;
      if (bus_valid && bus_write) begin
        case (bus_addr)
          8'h00: begin r = bus_wdata[0]; a = bus_wdata[1]; end
          8'h04: l = bus_wdata;
          8'h08: c = bus_wdata;
          8'h0C: e = bus_wdata[0];
          8'h10: clr = bus_wdata[0];
          8'h14: begin l = bus_wdata; c = bus_wdata; r = 1; end
          default: ;
        endcase
      end
      if (wrap) s = 1;
      else if (clr) s = 0;
      m_cnt <= c; m_load <= l; m_run <= r; m_ar <= a; m_ie <= e; m_sts <= s;
    end
  end

  function automatic logic [W-1:0] mread(input logic [AW-1:0] a);
    case (a)
      8'h00: return {30'd0, m_ar, m_run};
      8'h04: return m_load;
      8'h08: return m_cnt;
      8'h0C: return {31'd0, m_ie};
      8'h10: return {31'd0, m_sts};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every clock: irq against the model (R7)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) chk("R7 irq per cycle", {31'd0, irq}, {31'd0, m_ie & m_sts});
  end

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_wdata = 0;
    #1;
    v = bus_rdata;
    chk(req, v, mread(a));
    chk("bus ready", {31'd0, bus_ready}, 32'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] v, v2;
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int k = 0; k < 6; k++) begin
      rd("R1 reset read", AW'(k * 4), v);
      chk("R1 reset value", v, 0);
    end
    chk("R1 irq low", {31'd0, irq}, 0);

    // R2 / R10 counting and live reads
    wr(8'h04, 32'h0000_1234);
    wr(8'h08, 32'h0000_0100);
    wr(8'h00, 32'h1);
    idle(5);
    rd("R2 counter running", 8'h08, v);
    rd("R10 live read", 8'h08, v2);
    chk("R2 one per clock", v2, v + 1);
    wr(8'h08, 32'h0000_0050);
    rd("R10 write beats count", 8'h08, v);
    chk("R10 written value", v, 32'h50);

    // R9 stop
    wr(8'h00, 32'h0);
    idle(3);
    rd("R9 held", 8'h08, v);
    rd("R9 held again", 8'h08, v2);
    chk("R9 no change", v2, v);
    rd("R9 load kept", 8'h04, v);
    chk("R9 load value", v, 32'h1234);

    // R8 / R4 / R3 periodic
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h2);
    wr(8'h14, 32'hFFFF_FFFC);
    rd("R8 load", 8'h04, v);
    chk("R8 load value", v, 32'hFFFF_FFFC);
    rd("R8 ctrl", 8'h00, v);
    chk("R8 run set, ar kept", v, 32'h3);
    idle(6);
    rd("R3 flag", 8'h10, v);
    chk("R3 flag set", v, 1);
    rd("R4 counter", 8'h08, v);
    chk("R7 irq high", {31'd0, irq}, 1);
    wr(8'h00, 32'h2);
    rd("R4 ar kept after stop", 8'h00, v);

    // R7 gating
    wr(8'h0C, 32'h0);
    idle(1);
    chk("R7 irq masked", {31'd0, irq}, 0);
    wr(8'h0C, 32'h1);

    // R6 write-one-to-clear
    wr(8'h10, 32'h0);
    rd("R6 zero write", 8'h10, v);
    chk("R6 flag kept", v, 1);
    wr(8'h10, 32'h1);
    rd("R6 cleared", 8'h10, v);
    chk("R6 flag clear", v, 0);

    // R6 collision of clear with wrap
    wr(8'h14, 32'hFFFF_FFFC);
    idle(3);
    wr(8'h10, 32'h1);
    wr(8'h00, 32'h0);
    rd("R6 set wins", 8'h10, v);
    chk("R6 set wins value", v, 1);

    // R5 one-shot
    wr(8'h10, 32'h1);
    wr(8'h14, 32'hFFFF_FFFE);
    idle(5);
    rd("R5 ctrl", 8'h00, v);
    chk("R5 run cleared", v, 0);
    rd("R5 counter", 8'h08, v);
    chk("R5 wrapped to zero", v, 0);
    rd("R3 one-shot flag", 8'h10, v);
    chk("R3 one-shot flag set", v, 1);

    // R11 unmapped
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd("R11 unmapped read", 8'h18, v);
    chk("R11 zero", v, 0);
    rd("R11 ldst reads zero", 8'h14, v);
    chk("R11 ldst zero", v, 0);
    rd("R11 ctrl untouched", 8'h00, v);
    chk("R11 ctrl value", v, 0);
    rd("R11 load untouched", 8'h04, v);
    chk("R11 load value", v, 32'hFFFF_FFFE);
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule